// File: doc/BRIEF.md
# Audio Frame Transmit Formatter

This block serialises multichannel audio words into a frame on a single data pin. A frame holds one or two subframes. Each subframe carries a programmable number of channels, and every channel has a programmable bit length. After the last data bit, the block can append a programmable run of padding bits. During the padding the pin driver is released, so the frame period can be set apart from the amount of payload.

The block advances one bit per `bit_en_i` pulse, which comes from an external bit-clock divider. Words are pulled through a valid/ready handshake at the moment the first bit of each channel goes out. A frame-sync strobe marks the first bit of every frame. The configuration inputs are captured when a frame begins, so software can update them at any time without corrupting a frame already in progress.

Top module: `aft_top`

## Requirements
- R1: After reset `sd_o`, `sd_oe_o`, `fs_o` and `underrun_o` are low. The first `bit_en_i` pulse after reset starts a frame.
- R2: `sd_o`, `sd_oe_o` and `fs_o` change only at clock edges where `bit_en_i` is high, and they hold their value between pulses.
- R3: With `two_sub_i`=0, a frame lasts (`chl0_i`+1)×(`chn0_i`+1)+`ovhd_i` bit pulses.
- R4: With `two_sub_i`=1, a frame adds (`chl1_i`+1)×(`chn1_i`+1) data bits. These come from the subframe-1 channels, which are sent after all subframe-0 channels.
- R5: Each channel takes one word, and the word supplies its low L+1 bits, where L is that subframe's channel length. The bits go out starting at bit L and ending at bit 0. `word_ready_o` is high, together with `bit_en_i`, during the pulse that emits bit L, and the word is consumed when `word_valid_i` is also high.
- R6: The padding bits follow the data. During padding `sd_oe_o`=0 and `sd_o`=0. During data bits `sd_oe_o`=1.
- R7: With `ovhd_i`=0 the next frame's first bit follows the last data bit directly, with no released bit.
- R8: `fs_o` is 1 for exactly the first bit of each frame and 0 for every other bit.
- R9: If `word_valid_i` is low when a word is needed, that channel is sent as zeros and `underrun_o` rises. `underrun_o` then stays high until reset.
- R10: The configuration inputs are sampled only at the first bit of a frame. A change made later in the frame has no effect until the next frame.
- R11: `ovhd_i` accepts its full range up to 1023 padding bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | Bit-clock enable, one pulse per serial bit |
| two_sub_i | input | 1 | 1: frame has two subframes |
| chl0_i | input | 5 | Subframe-0 channel length minus one |
| chn0_i | input | 4 | Subframe-0 channel count minus one |
| chl1_i | input | 5 | Subframe-1 channel length minus one |
| chn1_i | input | 4 | Subframe-1 channel count minus one |
| ovhd_i | input | 10 | Padding bits appended per frame |
| word_i | input | 32 | Channel word |
| word_valid_i | input | 1 | Channel word available |
| word_ready_o | output | 1 | Channel word taken at this edge |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Data pin drive enable |
| fs_o | output | 1 | Frame sync, first bit of frame |
| underrun_o | output | 1 | Sticky word underrun |

## Verification
The framing is driven with several configurations:
- A single subframe with padding, which tests the length formula and the released pin during padding.
- Two unequal subframes with no padding, back to back, which tests subframe order and frame-to-frame joining.
- Full-width 32-bit channels, which test the top bit index.
- A one-bit frame with 1023 padding bits, which tests the widest padding count.

Scrambling the configuration inputs after a frame's first bit shows whether the configuration is captured only at frame start. Stopping the word supply partway through a frame separates the zero fill and the sticky flag from normal data.

// File: rtl/aft_pkg.sv
package aft_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_PAD} aft_phase_e;
endpackage

// File: rtl/aft_seq.sv
module aft_seq
  import aft_pkg::*;
#(
  parameter int CHL_W  = 5,
  parameter int CHN_W  = 4,
  parameter int OVHD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              two_sub_i,
  input  logic [CHL_W-1:0]  chl0_i,
  input  logic [CHN_W-1:0]  chn0_i,
  input  logic [CHL_W-1:0]  chl1_i,
  input  logic [CHN_W-1:0]  chn1_i,
  input  logic [OVHD_W-1:0] ovhd_i,
  output logic              start_o,
  output logic              load_o,
  output logic              data_o,
  output logic [CHL_W-1:0]  idx_o
);
  aft_phase_e phase_q, phase_n;
  logic              sub_q, sub_n;
  logic [CHN_W-1:0]  ch_q, ch_n;
  logic [CHL_W-1:0]  idx_q, idx_n;
  logic [OVHD_W-1:0] pad_q, pad_n;
  logic              two_q;
  logic [CHL_W-1:0]  chl_q [2];
  logic [CHN_W-1:0]  chn_q [2];
  logic [OVHD_W-1:0] ovhd_q;
  logic              start, load;
  logic [CHL_W-1:0]  cur_chl;
  logic [CHN_W-1:0]  cur_chn;

  assign cur_chl = chl_q[sub_q];
  assign cur_chn = chn_q[sub_q];

  always_comb begin
    phase_n = phase_q;
    sub_n   = sub_q;
    ch_n    = ch_q;
    idx_n   = idx_q;
    pad_n   = pad_q;
    start   = 1'b0;
    load    = 1'b0;
    unique case (phase_q)
      PH_IDLE: start = 1'b1;
      PH_DATA: begin
        if (idx_q != '0) begin
          idx_n = idx_q - 1'b1;
        end else if (ch_q != cur_chn) begin
          ch_n  = ch_q + 1'b1;
          idx_n = cur_chl;
          load  = 1'b1;
        end else if (!sub_q && two_q) begin
          sub_n = 1'b1;
          ch_n  = '0;
          idx_n = chl_q[1];
          load  = 1'b1;
        end else if (ovhd_q != '0) begin
          phase_n = PH_PAD;
          pad_n   = ovhd_q - 1'b1;
        end else begin
          start = 1'b1;
        end
      end
      PH_PAD: begin
        if (pad_q != '0) pad_n = pad_q - 1'b1;
        else             start = 1'b1;
      end
      default: start = 1'b1;
    endcase
    if (start) begin
      phase_n = PH_DATA;
      sub_n   = 1'b0;
      ch_n    = '0;
      idx_n   = chl0_i;
      load    = 1'b1;
    end
  end

  assign start_o = bit_en_i & start;
  assign load_o  = bit_en_i & load;
  assign data_o  = (phase_n == PH_DATA);
  assign idx_o   = idx_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      sub_q    <= 1'b0;
      ch_q     <= '0;
      idx_q    <= '0;
      pad_q    <= '0;
      two_q    <= 1'b0;
      chl_q[0] <= '0;
      chl_q[1] <= '0;
      chn_q[0] <= '0;
      chn_q[1] <= '0;
      ovhd_q   <= '0;
    end else if (bit_en_i) begin
      phase_q <= phase_n;
      sub_q   <= sub_n;
      ch_q    <= ch_n;
      idx_q   <= idx_n;
      pad_q   <= pad_n;
      if (start) begin
        two_q    <= two_sub_i;
        chl_q[0] <= chl0_i;
        chl_q[1] <= chl1_i;
        chn_q[0] <= chn0_i;
        chn_q[1] <= chn1_i;
        ovhd_q   <= ovhd_i;
      end
    end
  end

  // R11: padding countdown stays inside the captured count
  a_r11_pad_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PAD) |-> (pad_q < ovhd_q));
  // R4: second subframe only when captured config asked for it
  a_r4_sub1_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q |-> two_q);
endmodule

// File: rtl/aft_shift.sv
module aft_shift #(
  parameter int CHL_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              start_i,
  input  logic              load_i,
  input  logic              data_i,
  input  logic [CHL_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic              fs_o,
  output logic              underrun_o
);
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] word_eff;

  assign word_eff = word_valid_i ? word_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      sd_o       <= 1'b0;
      sd_oe_o    <= 1'b0;
      fs_o       <= 1'b0;
      underrun_o <= 1'b0;
    end else if (bit_en_i) begin
      fs_o    <= start_i;
      sd_oe_o <= data_i;
      if (load_i) begin
        shreg_q <= word_eff;
        sd_o    <= word_eff[idx_i];
        if (!word_valid_i) underrun_o <= 1'b1;
      end else if (data_i) begin
        sd_o <= shreg_q[idx_i];
      end else begin
        sd_o <= 1'b0;
      end
    end
  end

  a_r8_fs_on_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o |-> sd_oe_o);
  a_r6_pad_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_oe_o |-> !sd_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable({sd_o, sd_oe_o, fs_o}));
endmodule

// File: rtl/aft_top.sv
module aft_top #(
  parameter int CHL_W  = 5,
  parameter int CHN_W  = 4,
  parameter int OVHD_W = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bit_en_i,
  input  logic                  two_sub_i,
  input  logic [CHL_W-1:0]      chl0_i,
  input  logic [CHN_W-1:0]      chn0_i,
  input  logic [CHL_W-1:0]      chl1_i,
  input  logic [CHN_W-1:0]      chn1_i,
  input  logic [OVHD_W-1:0]     ovhd_i,
  input  logic [(1<<CHL_W)-1:0] word_i,
  input  logic                  word_valid_i,
  output logic                  word_ready_o,
  output logic                  sd_o,
  output logic                  sd_oe_o,
  output logic                  fs_o,
  output logic                  underrun_o
);
  localparam int DATA_W = 1 << CHL_W;

  logic             start, load, data;
  logic [CHL_W-1:0] idx;

  aft_seq #(.CHL_W(CHL_W), .CHN_W(CHN_W), .OVHD_W(OVHD_W)) u_seq (
    .clk_i, .rst_ni, .bit_en_i, .two_sub_i,
    .chl0_i, .chn0_i, .chl1_i, .chn1_i, .ovhd_i,
    .start_o(start), .load_o(load), .data_o(data), .idx_o(idx)
  );

  aft_shift #(.CHL_W(CHL_W), .DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .bit_en_i,
    .start_i(start), .load_i(load), .data_i(data), .idx_i(idx),
    .word_i, .word_valid_i,
    .sd_o, .sd_oe_o, .fs_o, .underrun_o
  );

  assign word_ready_o = load;

  a_r5_ready_on_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> bit_en_i);
  a_r8_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && start) |=> fs_o && sd_oe_o);
endmodule

// File: tb/aft_top_bench.sv
module aft_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, two_sub = 1'b0, word_valid = 1'b0;
  logic [4:0] chl0 = '0, chl1 = '0;
  logic [3:0] chn0 = '0, chn1 = '0;
  logic [9:0] ovhd = '0;
  logic [31:0] word = '0;
  logic word_ready, sd, sd_oe, fs, underrun;

  int checks = 0, fails = 0;
  int wp = 0, nvalid = 64;
  logic [31:0] words [64];

  always #2.5 clk = ~clk;

  aft_top u_aft_top (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .two_sub_i(two_sub),
    .chl0_i(chl0), .chn0_i(chn0), .chl1_i(chl1), .chn1_i(chn1), .ovhd_i(ovhd),
    .word_i(word), .word_valid_i(word_valid), .word_ready_o(word_ready),
    .sd_o(sd), .sd_oe_o(sd_oe), .fs_o(fs), .underrun_o(underrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bit pulse; outputs sampled at the following negedge
  task automatic step();
    logic took;
    @(negedge clk);
    bit_en     = 1'b1;
    word_valid = (wp < nvalid);
    word       = (wp < nvalid) ? words[wp] : 32'h0;
    #1 took = word_ready & word_valid;
    @(negedge clk);
    bit_en     = 1'b0;
    word_valid = 1'b0;
    if (took) wp++;
  endtask

  task automatic run_frame(input string tag, input bit two, input int c0l, input int c0n,
                           input int c1l, input int c1n, input int ov, input bit scramble);
    bit first = 1'b1;
    int nbits = 0;
    two_sub = two; chl0 = c0l[4:0]; chn0 = c0n[3:0];
    chl1 = c1l[4:0]; chn1 = c1n[3:0]; ovhd = ov[9:0];
    for (int s = 0; s < (two ? 2 : 1); s++) begin
      int l = s ? c1l : c0l;
      int n = s ? c1n : c0n;
      for (int c = 0; c <= n; c++) begin
        logic [31:0] w = (wp < nvalid) ? words[wp] : 32'h0;
        for (int b = l; b >= 0; b--) begin
          step();
          nbits++;
          check({tag, " data"}, {29'b0, fs, sd_oe, sd}, {29'b0, first, 1'b1, w[b]});
          if (first && scramble) begin
            two_sub = ~two; chl0 = 5'd2; chn0 = 4'd0; chl1 = 5'd1; chn1 = 4'd3; ovhd = 10'd5;
          end
          first = 1'b0;
        end
      end
    end
    for (int p = 0; p < ov; p++) begin
      step();
      nbits++;
      check({tag, " pad"}, {29'b0, fs, sd_oe, sd}, 32'h0);
    end
    check({tag, " length"}, nbits,
          (c0l + 1) * (c0n + 1) + (two ? (c1l + 1) * (c1n + 1) : 0) + ov);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {28'b0, sd, sd_oe, fs, underrun}, 32'h0);
    check("R1 reset ready", {31'b0, word_ready}, 32'h0);
  endtask

  task automatic t_single_pad();
    run_frame("R3 R6 single sub pad", 1'b0, 7, 1, 0, 0, 3, 1'b0);
    run_frame("R8 R5 single sub next", 1'b0, 7, 1, 0, 0, 3, 1'b0);
  endtask

  task automatic t_hold();
    logic [2:0] snap;
    run_frame("R2 prep", 1'b0, 3, 0, 0, 0, 2, 1'b0);
    step();
    snap = {fs, sd_oe, sd};
    repeat (5) @(negedge clk);
    check("R2 hold without enable", {29'b0, fs, sd_oe, sd}, {29'b0, snap});
    // complete the frame begun above: 4 data bits, 2 pad
    for (int i = 0; i < 5; i++) step();
  endtask

  task automatic t_two_sub();
    run_frame("R4 R7 two subs", 1'b1, 5, 1, 3, 2, 0, 1'b0);
    run_frame("R4 R7 two subs again", 1'b1, 5, 1, 3, 2, 0, 1'b0);
  endtask

  task automatic t_full_width();
    run_frame("R5 full width", 1'b0, 31, 1, 0, 0, 1, 1'b0);
  endtask

  task automatic t_scramble();
    run_frame("R10 cfg held", 1'b1, 4, 2, 2, 1, 4, 1'b1);
    run_frame("R10 cfg next", 1'b0, 2, 0, 0, 0, 0, 1'b0);
  endtask

  task automatic t_max_pad();
    run_frame("R11 max pad", 1'b0, 0, 0, 0, 0, 1023, 1'b0);
  endtask

  task automatic t_underrun();
    check("R9 no underrun before", {31'b0, underrun}, 32'h0);
    nvalid = wp + 1;
    run_frame("R9 zero fill", 1'b0, 7, 2, 0, 0, 2, 1'b0);
    check("R9 flag set", {31'b0, underrun}, 32'h1);
    nvalid = 64;
    run_frame("R9 recover", 1'b0, 3, 1, 0, 0, 1, 1'b0);
    check("R9 flag sticky", {31'b0, underrun}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) words[i] = 32'hA5C3_0F1E ^ (i * 32'h9E37_79B9);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single_pad();
    t_hold();
    t_two_sub();
    t_full_width();
    t_scramble();
    t_max_pad();
    t_underrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule